// File: doc/BRIEF.md
# Timestamp Event Capture Unit

This block runs a 32-bit time counter and records timestamped events into a small event queue that software reads over a 32-bit register bus. An event can come from a software push write, from the counter wrapping to zero or crossing its midpoint, from a rising edge on one of four hardware pins, or from a receive or transmit strobe of an Ethernet port. Strobes from a port carry a port number, a message type and a sequence ID.

Software enables the counter and can load it with a new value. It reads the oldest queued event as a timestamp word and a descriptor word, and then discards that event by writing a pop register. A single interrupt line reports a non-empty queue, gated by an enable bit. Lost events set a sticky flag. The counter and the capture logic share one clock.

Top module: `ts_event_unit`

## Requirements
- R1: After reset the counter is 0, the queue is empty, control (0x04) reads 0, irq is low, and the identity word at 0x00 reads {ID_VAL[15:0], RTL_REV[4:0], MAJ_REV[2:0], MIN_REV[7:0]}.
- R2: While control bit 0 is set, the counter adds 1 every cycle. While that bit is clear, the counter holds. Writing 1 to bit 0 of 0x14 copies the word at 0x10 into the counter whether or not counting is enabled, and the load wins over the increment in that cycle.
- R3: Writing 1 to bit 0 of 0x0C queues an event of type 0. Its timestamp is the counter value in the cycle of the write, and its port, message and sequence fields are 0.
- R4: When the counter steps from 0xFFFFFFFF to 0, an event of type 1 with timestamp 0 is queued. When it steps from 0x7FFFFFFF to 0x80000000, an event of type 2 with timestamp 0x80000000 is queued.
- R5: A rising edge on hw_pin[i] queues an event of type 3 with port field i+1, but only when control bit 8+i is set. Edges on disabled pins are ignored.
- R6: A receive strobe queues an event of type 4 and a transmit strobe queues an event of type 5. Each event carries the strobe's port, message type and sequence ID.
- R7: The descriptor word at 0x38 holds the port in bits 28:24, the type in bits 23:20, the message type in bits 19:16 and the sequence ID in bits 15:0. The timestamp word is read at 0x34.
- R8: Events leave the queue in arrival order. Writing 1 to bit 0 of 0x30 discards the oldest event. A pop on an empty queue has no effect. Both head words read 0 while the queue is empty.
- R9: An event that arrives while the queue holds DEPTH entries is dropped, even in a cycle that pops, and bit 1 of 0x20 becomes set. That bit stays set until software writes 1 to bit 1 of 0x20.
- R10: When several events arrive in one cycle, only one is queued. The priority is transmit, then receive, then pins 1 to 4, then software push, then counter events. The other events are dropped and set the same sticky flag as R9.
- R11: Bit 0 of 0x20 is set while the queue is non-empty or while control bit 1 is set. Bit 0 of 0x24 and irq are both that bit ANDed with bit 0 of 0x28.
- R12: While control bit 0 is clear, no event of any kind is queued.
- R13: Control bits 0, 1 and 11:8, the clock select field at 0x08 (bits 4:0), the load value at 0x10 and the interrupt enable at 0x28 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 6 | Byte address of register |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| hw_pin | input | 4 | Hardware push pins, synchronous to clk |
| rx_stb | input | 1 | Receive event strobe |
| rx_port | input | 5 | Receive port number |
| rx_msg | input | 4 | Receive message type |
| rx_seq | input | 16 | Receive sequence ID |
| tx_stb | input | 1 | Transmit event strobe |
| tx_port | input | 5 | Transmit port number |
| tx_msg | input | 4 | Transmit message type |
| tx_seq | input | 16 | Transmit sequence ID |
| irq | output | 1 | Pending-event interrupt |

## Verification
The bench builds the unit with DEPTH=4, so five back-to-back pushes are enough to fill the queue and show the drop and sticky-flag behaviour. The identity fields keep their default values, which lets the bench check them as constants. The counter stays 32 bits wide. Loading it a few counts before 0x7FFFFFFF or 0xFFFFFFFF brings both wrap events within a few cycles.

// File: rtl/ts_event_unit.sv
module ts_event_unit #(
  parameter int DEPTH = 16,
  parameter logic [15:0] ID_VAL = 16'h4E8A,
  parameter logic [4:0]  RTL_REV = 5'd1,
  parameter logic [2:0]  MAJ_REV = 3'd2,
  parameter logic [7:0]  MIN_REV = 8'h0C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [3:0]  hw_pin,
  input  logic        rx_stb,
  input  logic [4:0]  rx_port,
  input  logic [3:0]  rx_msg,
  input  logic [15:0] rx_seq,
  input  logic        tx_stb,
  input  logic [4:0]  tx_port,
  input  logic [3:0]  tx_msg,
  input  logic [15:0] tx_seq,
  output logic        irq
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

  logic        run_q, test_q, ie_q, ovf_q;
  logic [3:0]  pin_en_q, pin_q;
  logic [4:0]  rsel_q;
  logic [31:0] ldval_q, cnt_q;
  logic [31:0] lo_mem [DEPTH];
  logic [31:0] hi_mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [PW:0] count;

  wire wr_ctrl = reg_wen && reg_addr == 6'h04;
  wire wr_rsel = reg_wen && reg_addr == 6'h08;
  wire wr_push = reg_wen && reg_addr == 6'h0C;
  wire wr_ldv  = reg_wen && reg_addr == 6'h10;
  wire wr_lde  = reg_wen && reg_addr == 6'h14;
  wire wr_raw  = reg_wen && reg_addr == 6'h20;
  wire wr_ie   = reg_wen && reg_addr == 6'h28;
  wire wr_pop  = reg_wen && reg_addr == 6'h30;

  wire ld_go    = wr_lde & reg_wdata[0];
  wire push_req = run_q & wr_push & reg_wdata[0];
  wire roll_req = run_q & ~ld_go & (cnt_q == 32'hFFFF_FFFF);
  wire half_req = run_q & ~ld_go & (cnt_q == 32'h7FFF_FFFF);
  wire [3:0] pin_rise = hw_pin & ~pin_q & pin_en_q & {4{run_q}};
  wire [8:0] req = {run_q & tx_stb, run_q & rx_stb, pin_rise, push_req, roll_req, half_req};
  wire evt_valid = |req;
  wire multi     = |(req & (req - 9'd1));
  wire empty     = count == '0;
  wire full      = count == FULL_CNT;
  wire accept    = evt_valid & ~full;
  wire popping   = wr_pop & reg_wdata[0] & ~empty;
  wire raw_pend  = ~empty | test_q;

  assign irq = raw_pend & ie_q;

  logic [4:0]  pin_num;
  logic [31:0] evt_hi, evt_lo;

  always_comb begin
    pin_num = '0;
    for (int i = 3; i >= 0; i--)
      if (pin_rise[i]) pin_num = 5'(i + 1);
  end

  always_comb begin
    evt_lo = cnt_q;
    evt_hi = '0;
    if (req[8])           evt_hi = {3'd0, tx_port, 4'd5, tx_msg, tx_seq};
    else if (req[7])      evt_hi = {3'd0, rx_port, 4'd4, rx_msg, rx_seq};
    else if (|pin_rise)   evt_hi = {3'd0, pin_num, 4'd3, 20'd0};
    else if (push_req)    evt_hi = {8'd0, 4'd0, 20'd0};
    else if (roll_req) begin
      evt_hi = {8'd0, 4'd1, 20'd0};
      evt_lo = 32'h0;
    end else if (half_req) begin
      evt_hi = {8'd0, 4'd2, 20'd0};
      evt_lo = 32'h8000_0000;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; test_q <= 1'b0; pin_en_q <= '0; rsel_q <= '0;
      ldval_q <= '0; ie_q <= 1'b0; ovf_q <= 1'b0; cnt_q <= '0; pin_q <= '0;
      rp <= '0; wp <= '0; count <= '0;
    end else begin
      pin_q <= hw_pin;
      if (wr_ctrl) begin
        run_q <= reg_wdata[0];
        test_q <= reg_wdata[1];
        pin_en_q <= reg_wdata[11:8];
      end
      if (wr_rsel) rsel_q <= reg_wdata[4:0];
      if (wr_ldv) ldval_q <= reg_wdata;
      if (wr_ie) ie_q <= reg_wdata[0];
      if (ld_go) cnt_q <= ldval_q;
      else if (run_q) cnt_q <= cnt_q + 32'd1;
      if ((evt_valid & full) | multi) ovf_q <= 1'b1;
      else if (wr_raw & reg_wdata[1]) ovf_q <= 1'b0;
      if (accept) wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
      if (popping) rp <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
      count <= count + (PW+1)'(accept) - (PW+1)'(popping);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      lo_mem[wp] <= evt_lo;
      hi_mem[wp] <= evt_hi;
    end
  end

  always_comb begin
    case (reg_addr)
      6'h00: reg_rdata = {ID_VAL, RTL_REV, MAJ_REV, MIN_REV};
      6'h04: reg_rdata = {20'd0, pin_en_q, 6'd0, test_q, run_q};
      6'h08: reg_rdata = {27'd0, rsel_q};
      6'h10: reg_rdata = ldval_q;
      6'h20: reg_rdata = {30'd0, ovf_q, raw_pend};
      6'h24: reg_rdata = {31'd0, irq};
      6'h28: reg_rdata = {31'd0, ie_q};
      6'h34: reg_rdata = empty ? 32'd0 : lo_mem[rp];
      6'h38: reg_rdata = empty ? 32'd0 : hi_mem[rp];
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL_CNT); // R9
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (full && !popping) |=> full); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (ovf_q && !(wr_raw && reg_wdata[1])) |=> ovf_q); // R9
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !ld_go) |=> $stable(cnt_q)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (run_q && !ld_go) |=> cnt_q == $past(cnt_q) + 32'd1); // R2
  AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!run_q && !popping) |=> count == $past(count)); // R12
endmodule

// File: tb/ts_event_unit_test.sv
module ts_event_unit_test;
  logic clk = 0, rst_n = 0;
  logic [5:0] reg_addr = 0;
  logic reg_wen = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0] hw_pin = 0;
  logic rx_stb = 0, tx_stb = 0;
  logic [4:0] rx_port = 0, tx_port = 0;
  logic [3:0] rx_msg = 0, tx_msg = 0;
  logic [15:0] rx_seq = 0, tx_seq = 0;
  logic irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [63:0] expq[$];
  logic [31:0] mcnt = 0, mld = 0;
  bit men = 0;

  always #2 clk = ~clk;

  ts_event_unit #(.DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_pin(hw_pin),
    .rx_stb(rx_stb), .rx_port(rx_port), .rx_msg(rx_msg), .rx_seq(rx_seq),
    .tx_stb(tx_stb), .tx_port(tx_port), .tx_msg(tx_msg), .tx_seq(tx_seq),
    .irq(irq));

  // counter model from R2
  always @(posedge clk) begin
    if (rst_n) begin
      if (reg_wen && reg_addr == 6'h14 && reg_wdata[0]) mcnt <= mld;
      else if (men) mcnt <= mcnt + 1;
      if (reg_wen && reg_addr == 6'h04) men <= reg_wdata[0];
      if (reg_wen && reg_addr == 6'h10) mld <= reg_wdata;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1;
    @(negedge clk);
    reg_wen = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic logic [63:0] ev(logic [4:0] port, logic [3:0] typ, logic [3:0] msg, logic [15:0] seq, logic [31:0] ts);
    return {3'd0, port, typ, msg, seq, ts};
  endfunction

  task automatic push_sw(bit expect_it);
    if (expect_it) expq.push_back(ev(0, 0, 0, 0, mcnt));
    wr(6'h0C, 1);
  endtask

  task automatic pin_pulse(int i, bit expect_it);
    if (expect_it) expq.push_back(ev(5'(i + 1), 3, 0, 0, mcnt));
    hw_pin[i] = 1;
    @(negedge clk);
    hw_pin[i] = 0;
    @(negedge clk);
  endtask

  task automatic eth(bit tx, logic [4:0] p, logic [3:0] m, logic [15:0] s, bit expect_it);
    if (expect_it) expq.push_back(ev(p, tx ? 4'd5 : 4'd4, m, s, mcnt));
    if (tx) begin tx_stb = 1; tx_port = p; tx_msg = m; tx_seq = s; end
    else begin rx_stb = 1; rx_port = p; rx_msg = m; rx_seq = s; end
    @(negedge clk);
    tx_stb = 0; rx_stb = 0;
  endtask

  // monitor: pops the design queue and compares with the scoreboard
  task automatic drain(string req);
    logic [31:0] lo, hi;
    while (expq.size() > 0) begin
      logic [63:0] e = expq.pop_front();
      rd(6'h38, hi); chk({req, " desc"}, hi, e[63:32]);
      rd(6'h34, lo); chk({req, " stamp"}, lo, e[31:0]);
      @(negedge clk);
      wr(6'h30, 1);
    end
    rd(6'h20, lo); chk({req, " empty after drain"}, {31'd0, lo[0]}, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(6'h04, d); chk("R1 control", d, 0);
    rd(6'h00, d); chk("R1 identity", d, 32'h4E8A_0A0C);
    rd(6'h20, d); chk("R1 raw status", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    rd(6'h38, d); chk("R8 empty head desc", d, 0);
    @(negedge clk);

    // R13 readback
    wr(6'h08, 32'h15); wr(6'h10, 32'd100); wr(6'h28, 0);
    rd(6'h08, d); chk("R13 clock select", d, 32'h15);
    rd(6'h10, d); chk("R13 load value", d, 100);
    @(negedge clk);

    // R12 disabled: nothing recorded
    wr(6'h04, 32'hF00);
    push_sw(0); pin_pulse(0, 0); eth(1, 3, 2, 7, 0);
    rd(6'h20, d); chk("R12 no events while disabled", d, 0);
    rd(6'h04, d); chk("R13 control readback", d, 32'hF00);
    @(negedge clk);

    // R2/R3 load then push
    wr(6'h14, 1);
    wr(6'h04, 32'h1);
    push_sw(1);
    chk("R2 load value used as stamp", expq[0][31:0], 100);
    repeat (3) @(negedge clk);
    push_sw(1);
    wr(6'h04, 0);
    repeat (5) @(negedge clk);
    wr(6'h04, 1);
    push_sw(1);
    drain("R3");

    // R5 pins
    wr(6'h04, 32'h501);
    pin_pulse(0, 1); pin_pulse(2, 1); pin_pulse(1, 0); pin_pulse(3, 0);
    drain("R5");

    // R6/R7 Ethernet
    eth(0, 5'd17, 4'd9, 16'hBEEF, 1);
    eth(1, 5'd3, 4'd2, 16'h0042, 1);
    drain("R7");

    // R8 pop on empty
    wr(6'h30, 1);
    rd(6'h20, d); chk("R8 pop on empty", d, 0);
    eth(1, 5'd31, 4'd15, 16'hFFFF, 1);
    drain("R8");

    // R10 simultaneous tx, rx and push
    wr(6'h20, 2);
    expq.push_back(ev(4, 5, 1, 16'h1234, mcnt));
    tx_stb = 1; tx_port = 4; tx_msg = 1; tx_seq = 16'h1234;
    rx_stb = 1; rx_port = 6; rx_msg = 2; rx_seq = 16'h5555;
    wr(6'h0C, 1);
    tx_stb = 0; rx_stb = 0;
    rd(6'h20, d); chk("R10 lost flag", d, 3);
    drain("R10");
    wr(6'h20, 2);
    rd(6'h20, d); chk("R9 flag cleared", d, 0);
    @(negedge clk);

    // R9 full queue
    push_sw(1); push_sw(1); push_sw(1); push_sw(1); push_sw(0);
    rd(6'h20, d); chk("R9 overflow sticky", d, 3);
    wr(6'h20, 2);
    rd(6'h20, d); chk("R9 overflow cleared", d, 1);
    @(negedge clk);

    // R11 interrupt gating (queue is non-empty)
    chk("R11 irq masked", {31'd0, irq}, 0);
    rd(6'h24, d); chk("R11 masked status off", d, 0);
    @(negedge clk);
    wr(6'h28, 1);
    chk("R11 irq on", {31'd0, irq}, 1);
    rd(6'h24, d); chk("R11 masked status on", d, 1);
    @(negedge clk);
    drain("R9");
    chk("R11 irq off when empty", {31'd0, irq}, 0);
    wr(6'h04, 3);
    rd(6'h20, d); chk("R11 test bit", d, 1);
    chk("R11 test irq", {31'd0, irq}, 1);
    @(negedge clk);
    wr(6'h04, 0);

    // R4 wraps
    wr(6'h10, 32'hFFFF_FFFC); wr(6'h14, 1);
    expq.push_back(ev(0, 1, 0, 0, 0));
    wr(6'h04, 1);
    repeat (8) @(negedge clk);
    wr(6'h04, 0);
    drain("R4 rollover");
    wr(6'h10, 32'h7FFF_FFFD); wr(6'h14, 1);
    expq.push_back(ev(0, 2, 0, 0, 32'h8000_0000));
    wr(6'h04, 1);
    repeat (8) @(negedge clk);
    wr(6'h04, 0);
    drain("R4 half");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule